// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Bank

This block holds a bank of hardware breakpoints for an instruction pipeline. Each entry has a control word and a value word, plus a small virtual-machine identifier word. On every retiring instruction the bank checks each enabled entry against the instruction's address, size and privilege level, and against the current context and virtual-machine identifiers. It reports one registered hit bit per entry and a combined debug-event flag.

An entry can do one of three jobs. It can fire on one instruction address, with halfword and size selection. It can fire on every instruction except a selected one, which is how single-stepping works. It can fire on a context identifier, a virtual-machine identifier, or both. An address entry can also be chained to a context entry by index, so that it fires only while that context holds. Filtering by security state and by higher exception level is not provided, and those control bits are dropped on write.

Software or a debug agent loads the entries through a simple write port. The instruction stream feeds the compare side once per cycle.

Top module: `bkpt_match_unit`

## Requirements
- R1: Reset clears the enable bit (control bit 0) of every entry. An entry whose enable bit is 0 never hits, whatever its other fields hold.
- R2: Control bits [2:1] gate the hit by privilege. Bit 2 permits a hit when `ins_priv`=1 (privileged) and bit 1 permits it when `ins_priv`=0 (user). The value 00 never hits.
- R3: Type 0000 (control bits [23:20]) is an address match. Addresses compare on bits [31:2], and `ins_addr[0]` is ignored. The byte select in control bits [8:5] decides what matches:
  - 0011 matches a 16-bit instruction (`ins_is32`=0) with `ins_addr[1]`=0.
  - 1100 matches a 16-bit instruction with `ins_addr[1]`=1.
  - 1111 matches a 32-bit instruction (`ins_is32`=1) with `ins_addr[1]`=0.
- R4: Type 0100 is an address mismatch. It hits on every instruction that the byte select of R3 would not select. With byte select 0000 it hits on every instruction.
- R5: Context types:
  - Types 0010 and 0110 compare `ins_ctx` with the value word.
  - Type 1000 compares `ins_vmid` with the VMID word.
  - Type 1010 requires both comparisons.
  - These unlinked codes hit on their own, subject to R2.
  - Their linked variants (0011, 0111, 1001, 1011) never hit on their own.
- R6: The linked address types 0001 (match) and 0101 (mismatch) have an extra condition. They hit only if the entry named by control bits [19:16] is enabled, has a context type, and its comparison holds. The privilege field of that named entry is not consulted. For context types the byte select has no effect.
- R7: The following produce no hit:
  - a byte select other than 0011, 1100 or 1111 on type 0000;
  - a byte select other than 0000, 0011, 1100 or 1111 on type 0100;
  - any type code from 1100 to 1111;
  - a link index of N or more;
  - a link to an entry that is not a context type.
- R8: An instruction presented with `ins_valid`=1 before clock edge k shows its result on `hit_vec` after edge k. With `ins_valid`=0, `hit_vec` is all zero after that edge. `dbg_event` is the OR of `hit_vec` in the same cycle.
- R9: A write with `cfg_we`=1 stores `cfg_wdata` into entry `cfg_idx`. The target is chosen by `cfg_kind`: 00 selects the control word, 01 the value word, 10 the VMID word, and 11 stores nothing. The new setting applies to instructions presented after that edge. A write with `cfg_idx` of N or more changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Target word: 00 control, 01 value, 10 VMID |
| cfg_idx | input | 4 | Entry index for the write |
| cfg_wdata | input | DATA_W | Write data |
| ins_valid | input | 1 | Instruction on the compare inputs is retiring |
| ins_addr | input | DATA_W | Instruction address |
| ins_is32 | input | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| ins_priv | input | 1 | 1 privileged, 0 user |
| ins_ctx | input | DATA_W | Current context identifier |
| ins_vmid | input | VMID_W | Current virtual-machine identifier |
| hit_vec | output | NUM_BP | Registered per-entry hits |
| dbg_event | output | 1 | Registered OR of all hits |

## Verification
The assertions assume that reset is held for at least one clock edge before any use. They also assume that the instruction inputs are steady around each edge, and that configuration writes never coincide with a reset. The bench drives every input at the falling edge and holds reset for several cycles. It only changes configuration between instructions, so each instruction is compared against a settled set of entries. Link indices, reserved byte selects and unsupported type codes are applied deliberately, because the no-hit property must hold for them too.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef struct packed {
    logic [3:0] kind;   // compare mode
    logic [3:0] link;   // linked entry index
    logic [3:0] bsel;   // halfword select
    logic [1:0] plev;   // {privileged, user} permit
    logic       en;
  } bp_ctrl_t;

  function automatic logic priv_ok(input logic [1:0] plev, input logic priv);
    return (plev[1] & priv) | (plev[0] & ~priv);
  endfunction

  // context-family codes: 001x, 011x, 100x, 101x
  function automatic logic is_ctx_kind(input logic [3:0] kind);
    return (kind[3:1] == 3'b001) || (kind[3:1] == 3'b011) ||
           (kind[3:1] == 3'b100) || (kind[3:1] == 3'b101);
  endfunction

endpackage

// File: rtl/bkpt_cfg_store.sv
module bkpt_cfg_store
  import bkpt_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int DATA_W = 32,
  parameter int VMID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        kind,
  input  logic [3:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  output bp_ctrl_t          ctrl_o [NUM_BP],
  output logic [DATA_W-1:0] val_o  [NUM_BP],
  output logic [VMID_W-1:0] vmid_o [NUM_BP]
);

  bp_ctrl_t ctrl_w;
  assign ctrl_w = '{kind: wdata[23:20], link: wdata[19:16], bsel: wdata[8:5],
                    plev: wdata[2:1], en: wdata[0]};

  logic unused_bits;
  assign unused_bits = ^{wdata[DATA_W-1:24], wdata[15:9], wdata[4:3]};

  for (genvar i = 0; i < NUM_BP; i++) begin : g_ent
    logic sel;
    assign sel = we && (idx == 4'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_o[i] <= '0;
        val_o[i]  <= '0;
        vmid_o[i] <= '0;
      end else if (sel) begin
        case (kind)
          2'b00:   ctrl_o[i] <= ctrl_w;
          2'b01:   val_o[i]  <= wdata;
          2'b10:   vmid_o[i] <= wdata[VMID_W-1:0];
          default: ;
        endcase
      end
    end

    // R1
    reset_clears_en_chk: assert property (@(posedge clk) rst |=> !ctrl_o[i].en);
  end

endmodule

// File: rtl/bkpt_ctx_match.sv
module bkpt_ctx_match
  import bkpt_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int DATA_W = 32,
  parameter int VMID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bp_ctrl_t          ctrl_i [NUM_BP],
  input  logic [DATA_W-1:0] val_i  [NUM_BP],
  input  logic [VMID_W-1:0] vmid_i [NUM_BP],
  input  logic [DATA_W-1:0] ins_ctx,
  input  logic [VMID_W-1:0] ins_vmid,
  input  logic              ins_priv,
  output logic [NUM_BP-1:0] cond_o,  // link target condition
  output logic [NUM_BP-1:0] hit_o    // own hit
);

  for (genvar i = 0; i < NUM_BP; i++) begin : g_ent
    logic ctx_eq, vm_eq, cmp;
    assign ctx_eq = (ins_ctx == val_i[i]);
    assign vm_eq  = (ins_vmid == vmid_i[i]);

    always_comb begin
      case (ctrl_i[i].kind[3:1])
        3'b001, 3'b011: cmp = ctx_eq;
        3'b100:         cmp = vm_eq;
        3'b101:         cmp = ctx_eq & vm_eq;
        default:        cmp = 1'b0;
      endcase
    end

    assign cond_o[i] = ctrl_i[i].en & cmp;
    assign hit_o[i]  = cond_o[i] & ~ctrl_i[i].kind[0] & priv_ok(ctrl_i[i].plev, ins_priv);

    logic unused_bits;
    assign unused_bits = ^{ctrl_i[i].link, ctrl_i[i].bsel};

    // R1
    disabled_ctx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !ctrl_i[i].en |-> !cond_o[i] && !hit_o[i]);
    // R5
    linked_ctx_no_own_hit_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_i[i].kind[0] |-> !hit_o[i]);
  end

endmodule

// File: rtl/bkpt_addr_match.sv
module bkpt_addr_match
  import bkpt_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  bp_ctrl_t          ctrl_i [NUM_BP],
  input  logic [DATA_W-1:0] val_i  [NUM_BP],
  input  logic [NUM_BP-1:0] link_i,
  input  logic [DATA_W-1:0] ins_addr,
  input  logic              ins_is32,
  input  logic              ins_priv,
  output logic [NUM_BP-1:0] hit_o
);

  logic [15:0] link_ext;
  assign link_ext = 16'(link_i);

  logic unused_bits;
  assign unused_bits = ins_addr[0];

  for (genvar i = 0; i < NUM_BP; i++) begin : g_ent
    logic word_eq, legal, pick, base, link_ok;
    assign word_eq = (ins_addr[DATA_W-1:2] == val_i[i][DATA_W-1:2]);

    always_comb begin
      legal = 1'b1;
      case (ctrl_i[i].bsel)
        4'b0011: pick = word_eq & ~ins_addr[1] & ~ins_is32;
        4'b1100: pick = word_eq &  ins_addr[1] & ~ins_is32;
        4'b1111: pick = word_eq & ~ins_addr[1] &  ins_is32;
        default: begin pick = 1'b0; legal = 1'b0; end
      endcase
    end

    always_comb begin
      case (ctrl_i[i].kind[3:1])
        3'b000:  base = legal & pick;
        3'b010:  base = (ctrl_i[i].bsel == 4'b0000) ? 1'b1 : (legal & ~pick);
        default: base = 1'b0;
      endcase
    end

    assign link_ok = ~ctrl_i[i].kind[0] |
                     ((int'(ctrl_i[i].link) < NUM_BP) && link_ext[ctrl_i[i].link]);
    assign hit_o[i] = ctrl_i[i].en & base & link_ok & priv_ok(ctrl_i[i].plev, ins_priv);

    logic unused_val;
    assign unused_val = ^val_i[i][1:0];

    // R6
    linked_needs_target_chk: assert property (@(posedge clk) disable iff (rst)
      hit_o[i] && ctrl_i[i].kind[0] |->
        (int'(ctrl_i[i].link) < NUM_BP) && link_ext[ctrl_i[i].link]);
    // R7
    reserved_bsel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl_i[i].kind[3:1] == 3'b000) && !(ctrl_i[i].bsel inside {4'b0011, 4'b1100, 4'b1111})
        |-> !hit_o[i]);
    // R2
    priv_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl_i[i].plev == 2'b00) |-> !hit_o[i]);
  end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int DATA_W = 32,
  parameter int VMID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [3:0]        cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ins_valid,
  input  logic [DATA_W-1:0] ins_addr,
  input  logic              ins_is32,
  input  logic              ins_priv,
  input  logic [DATA_W-1:0] ins_ctx,
  input  logic [VMID_W-1:0] ins_vmid,
  output logic [NUM_BP-1:0] hit_vec,
  output logic              dbg_event
);

  bp_ctrl_t          ctrl [NUM_BP];
  logic [DATA_W-1:0] val  [NUM_BP];
  logic [VMID_W-1:0] vmid [NUM_BP];
  logic [NUM_BP-1:0] ctx_cond, ctx_hit, addr_hit, hit_comb;

  bkpt_cfg_store #(.NUM_BP(NUM_BP), .DATA_W(DATA_W), .VMID_W(VMID_W)) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .kind(cfg_kind), .idx(cfg_idx),
    .wdata(cfg_wdata), .ctrl_o(ctrl), .val_o(val), .vmid_o(vmid));

  bkpt_ctx_match #(.NUM_BP(NUM_BP), .DATA_W(DATA_W), .VMID_W(VMID_W)) u_ctx (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .val_i(val), .vmid_i(vmid),
    .ins_ctx(ins_ctx), .ins_vmid(ins_vmid), .ins_priv(ins_priv),
    .cond_o(ctx_cond), .hit_o(ctx_hit));

  bkpt_addr_match #(.NUM_BP(NUM_BP), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .val_i(val), .link_i(ctx_cond),
    .ins_addr(ins_addr), .ins_is32(ins_is32), .ins_priv(ins_priv), .hit_o(addr_hit));

  assign hit_comb = ctx_hit | addr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_vec   <= '0;
      dbg_event <= 1'b0;
    end else begin
      hit_vec   <= ins_valid ? hit_comb : '0;
      dbg_event <= ins_valid & (|hit_comb);
    end
  end

  // R8
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> (hit_vec == '0) && !dbg_event);
  // R8
  event_is_or_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_event == (hit_vec != '0));

endmodule

// File: tb/bkpt_match_unit_tb.sv
module bkpt_match_unit_tb;
  logic        clk = 0, rst = 1;
  logic        cfg_we = 0;
  logic [1:0]  cfg_kind = 0;
  logic [3:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic        ins_valid = 0, ins_is32 = 0, ins_priv = 0;
  logic [31:0] ins_addr = 0, ins_ctx = 0;
  logic [7:0]  ins_vmid = 0;
  logic [3:0]  hit_vec;
  logic        dbg_event;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bkpt_match_unit u_dut (.*);

  // {addr, is32, priv, ctx, expected hits}
  localparam logic [69:0] VEC [10] = '{
    {32'h1000, 1'b1, 1'b1, 32'h0,    4'b0001},  // R3 32-bit at base
    {32'h1000, 1'b0, 1'b1, 32'h0,    4'b0000},  // R3 wrong size
    {32'h1002, 1'b1, 1'b1, 32'h0,    4'b0000},  // R3 wrong halfword
    {32'h2002, 1'b0, 1'b1, 32'hABCD, 4'b0010},  // R6 link holds
    {32'h2002, 1'b0, 1'b1, 32'h1234, 4'b0000},  // R6 link fails
    {32'h2002, 1'b0, 1'b0, 32'hABCD, 4'b1000},  // R2 user: BP1 blocked, R4 BP3
    {32'h3000, 1'b0, 1'b0, 32'h0,    4'b0000},  // R4 stepped instruction
    {32'h3000, 1'b1, 1'b0, 32'h0,    4'b1000},  // R4 size differs
    {32'h3002, 1'b0, 1'b0, 32'h0,    4'b1000},  // R4 other halfword
    {32'h1000, 1'b1, 1'b0, 32'h0,    4'b1001}   // R2 both levels
  };

  task automatic wr(input logic [1:0] k, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_kind = k; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic check(input logic [3:0] exp, input string tag);
    n_chk++;
    if ({dbg_event, hit_vec} !== {|exp, exp}) begin
      n_bad++;
      $display("FAIL %s: hit=%b ev=%b expected hit=%b ev=%b", tag, hit_vec, dbg_event, exp, |exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic s32, input logic pv,
                     input logic [31:0] cx, input logic [7:0] vm, input logic vld,
                     input logic [3:0] exp, input string tag);
    @(negedge clk);
    ins_addr = a; ins_is32 = s32; ins_priv = pv; ins_ctx = cx; ins_vmid = vm; ins_valid = vld;
    @(negedge clk);
    check(exp, tag);
    ins_valid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(4'b0000, "R1 reset outputs");
    run(32'h0, 1'b0, 1'b1, 32'h0, 8'h0, 1'b1, 4'b0000, "R1 all disabled after reset");

    wr(2'b01, 4'd0, 32'h1000); wr(2'b00, 4'd0, 32'h0000_01E7);
    wr(2'b01, 4'd1, 32'h2000); wr(2'b00, 4'd1, 32'h0012_0185);
    wr(2'b01, 4'd2, 32'hABCD); wr(2'b00, 4'd2, 32'h0030_0007);
    wr(2'b01, 4'd3, 32'h3000); wr(2'b00, 4'd3, 32'h0040_0063);

    for (int k = 0; k < 10; k++)
      run(VEC[k][69:38], VEC[k][37], VEC[k][36], VEC[k][35:4], 8'h0, 1'b1,
          VEC[k][3:0], $sformatf("R3/R4/R6 vector %0d", k));

    run(32'h1000, 1'b1, 1'b1, 32'h0, 8'h0, 1'b0, 4'b0000, "R8 valid low");
    wr(2'b00, 4'd0, 32'h0000_01E1);
    run(32'h1000, 1'b1, 1'b1, 32'h0, 8'h0, 1'b1, 4'b0000, "R2 privilege field 00");
    wr(2'b00, 4'd0, 32'h0000_01E6);
    run(32'h1000, 1'b1, 1'b1, 32'h0, 8'h0, 1'b1, 4'b0000, "R1 enable clear");
    wr(2'b00, 4'd3, 32'h0);
    wr(2'b00, 4'd0, 32'h0000_00A7);
    run(32'h1000, 1'b1, 1'b1, 32'h0, 8'h0, 1'b1, 4'b0000, "R7 reserved byte select");
    wr(2'b00, 4'd0, 32'h00C0_0007);
    run(32'h1000, 1'b1, 1'b1, 32'h1000, 8'h0, 1'b1, 4'b0000, "R7 unsupported type");

    wr(2'b01, 4'd0, 32'h5555); wr(2'b00, 4'd0, 32'h0020_0007);
    run(32'h40, 1'b0, 1'b1, 32'h5555, 8'h0, 1'b1, 4'b0001, "R5 context hit");
    run(32'h40, 1'b0, 1'b1, 32'h5556, 8'h0, 1'b1, 4'b0000, "R5 context miss");
    wr(2'b10, 4'd0, 32'h3C); wr(2'b00, 4'd0, 32'h0080_0007);
    run(32'h40, 1'b0, 1'b1, 32'h9, 8'h3C, 1'b1, 4'b0001, "R5 vmid hit");
    run(32'h40, 1'b0, 1'b1, 32'h9, 8'h3D, 1'b1, 4'b0000, "R5 vmid miss");
    wr(2'b00, 4'd0, 32'h00A0_0007);
    run(32'h40, 1'b0, 1'b1, 32'h5555, 8'h3C, 1'b1, 4'b0001, "R5 both hit");
    run(32'h40, 1'b0, 1'b1, 32'h5555, 8'h3D, 1'b1, 4'b0000, "R5 both, vmid off");
    run(32'h40, 1'b0, 1'b1, 32'h5556, 8'h3C, 1'b1, 4'b0000, "R5 both, ctx off");

    wr(2'b00, 4'd1, 32'h0017_0185);
    run(32'h2002, 1'b0, 1'b1, 32'hABCD, 8'h0, 1'b1, 4'b0000, "R7 link index out of range");
    wr(2'b01, 4'd0, 32'h2000); wr(2'b00, 4'd0, 32'h0000_01E7);
    wr(2'b00, 4'd1, 32'h0010_0185);
    run(32'h2002, 1'b0, 1'b1, 32'hABCD, 8'h0, 1'b1, 4'b0000, "R7 link to address entry");

    wr(2'b00, 4'd3, 32'h0040_0007);
    run(32'h3000, 1'b0, 1'b1, 32'h0, 8'h0, 1'b1, 4'b1000, "R4 mismatch anywhere");
    wr(2'b00, 4'd9, 32'h0020_0007);
    run(32'h7000, 1'b0, 1'b1, 32'h2000, 8'h0, 1'b1, 4'b1000, "R9 out-of-range index ignored");
    wr(2'b11, 4'd3, 32'h0);
    run(32'h7000, 1'b0, 1'b1, 32'h0, 8'h0, 1'b1, 4'b1000, "R9 kind 11 stores nothing");

    wr(2'b00, 4'd1, 32'h0012_0185);
    run(32'h2002, 1'b0, 1'b1, 32'hABCD, 8'h0, 1'b1, 4'b1010, "R6 link restored");
    run(32'h2000, 1'b0, 1'b1, 32'hABCD, 8'h0, 1'b1, 4'b1000, "R3 halfword 0 not selected by 1100");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R8: run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule